// File: doc/BRIEF.md
# Privileged Segment Decoder and Fault Capture

This block sits between an address generator and a translation lookaside buffer. It takes a 32-bit virtual address, the kind of access (load, store or fetch) and the current privilege mode. It then decides which fixed segment the address falls in. Unmapped segments get their physical address straight from the virtual address, either unchanged or with a fixed base removed. Mapped segments raise a request toward the TLB, and the TLB's result code and physical address come back in the same cycle.

Every failure becomes a single fault with an exception class. A failure is either a segment the mode may not use, or a TLB result other than a hit. The class depends on whether the access was a store. Extra flags mark a refill (no matching entry) and a failed instruction fetch. On the clock edge of a faulting request, three fault registers are loaded: the bad virtual address, a context register that holds a page-table index, and an entry-high register that holds the faulting page pair. Fields of these registers that the fault does not own keep their values. Their starting contents come from reset parameters.

Top module: `vaSegDecode`

## Requirements
- R1: An address at or below 0x7FFFFFFF with the error-level flag set is passed through unchanged in every mode, without a TLB request and without a fault.
- R2: An address at or below 0x7FFFFFFF with the error-level flag clear raises a TLB request in every mode. When the TLB code is 0 (hit), the output physical address equals the TLB physical address.
- R3: Mode is decoded as 01 = supervisor, 10 = user, and anything else (00 or 11) = kernel. In kernel mode, 0x80000000..0x9FFFFFFF maps to the address minus 0x80000000, and 0xA0000000..0xBFFFFFFF maps to the address minus 0xA0000000, with no TLB request.
- R4: A non-kernel access to 0x80000000..0xBFFFFFFF, a user access to 0xC0000000..0xDFFFFFFF, and a non-kernel access at or above 0xE0000000 each fault with no TLB request. The class is 5 for a store (kind 01) and 4 otherwise.
- R5: 0xC0000000..0xDFFFFFFF is mapped for supervisor and kernel mode. 0xE0000000..0xFFFFFFFF is mapped for kernel mode only.
- R6: For a permitted mapped access, TLB code 1 (no match) and code 2 (invalid) fault with class 3 for a store and 2 otherwise. Code 3 (not writable) faults with class 1. The refill flag is high only for code 1.
- R7: TLB code 4 (execute inhibit) gives class 20 and code 5 (read inhibit) gives class 19 when the inhibit-exception enable is high. When the enable is low, both give class 2.
- R8: The fetch flag is high when a fault occurs on a fetch (kind 10). Access kind 11 is treated as a load.
- R9: On the clock edge of a fault, the bad-address register takes the full address. Context bits [22:0] become (address >> 9) & 0x007FFFF0, and context bits [31:23] are kept.
- R10: On the clock edge of a fault, entry-high keeps bits [7:0] (ASID) and bit 10 (invalidate), clears bits [12:11] and [9:8], and takes address bits [31:13] in bits [31:13].
- R11: With no request, or a request without a fault, the fault output and class are 0 and the three registers hold. During a fault the physical address output is 0.
- R12: After reset, the fault registers hold their reset parameter values: bad address 0, context 0xA5800000, entry-high 0x000007C3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Virtual address |
| reqKind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| privMode | input | 2 | 01 supervisor, 10 user, else kernel |
| errLevel | input | 1 | Error-level flag (user segment unmapped) |
| inhibitExcEn | input | 1 | Use dedicated inhibit classes |
| tlbCode | input | 3 | TLB result: 0 hit, 1 no match, 2 invalid, 3 not writable, 4 exec inhibit, 5 read inhibit |
| tlbPhys | input | 32 | TLB physical address |
| tlbReq | output | 1 | Lookup request to the TLB |
| physAddr | output | 32 | Physical address (0 on fault) |
| fault | output | 1 | Fault flag |
| excClass | output | 5 | Exception class (0 when no fault) |
| refillFlag | output | 1 | Fault was a TLB no-match |
| fetchFlag | output | 1 | Fault was on an instruction fetch |
| badVAddr | output | 32 | Bad virtual address register |
| contextReg | output | 32 | Context register |
| entryHiReg | output | 32 | Entry-high register |

## Verification
The hardest situation to reach is the register merge. A field kept across a fault can only be seen when the registers already hold non-zero bits outside the captured fields, and when several faults in a row overwrite the captured fields with different patterns. The bench relies on reset values that set the kept bits and also set the bits that must be cleared. It then chains faults at addresses with different high and middle bits. It ends with non-faulting and unstrobed requests to a forbidden segment, which show that the registers hold.

// File: rtl/segPkg.sv
package segPkg;
  localparam int ADDR_W = 32;
  localparam int CLS_W  = 5;

  localparam logic [2:0] TLB_HIT    = 3'd0;
  localparam logic [2:0] TLB_MISS   = 3'd1;
  localparam logic [2:0] TLB_INVAL  = 3'd2;
  localparam logic [2:0] TLB_RDONLY = 3'd3;
  localparam logic [2:0] TLB_NOEXEC = 3'd4;
  localparam logic [2:0] TLB_NOREAD = 3'd5;

  localparam logic [CLS_W-1:0] EXC_NONE    = 5'd0;
  localparam logic [CLS_W-1:0] EXC_MOD     = 5'd1;
  localparam logic [CLS_W-1:0] EXC_TLB_LD  = 5'd2;
  localparam logic [CLS_W-1:0] EXC_TLB_ST  = 5'd3;
  localparam logic [CLS_W-1:0] EXC_ADDR_LD = 5'd4;
  localparam logic [CLS_W-1:0] EXC_ADDR_ST = 5'd5;
  localparam logic [CLS_W-1:0] EXC_NOREAD  = 5'd19;
  localparam logic [CLS_W-1:0] EXC_NOEXEC  = 5'd20;

  typedef enum logic [1:0] {
    OFF_NONE = 2'd0,
    OFF_LOW  = 2'd1,
    OFF_HIGH = 2'd2
  } offSel_e;

  typedef struct packed {
    logic    fault;
    logic    capture;
    logic    useTlb;
    offSel_e offSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqKind,
  input  logic [1:0]            privMode,
  input  logic                  errLevel,
  input  logic                  inhibitExcEn,
  input  logic [2:0]            tlbCode,
  output ctrlStrobe_t           strobe,
  output logic                  tlbReq,
  output logic                  fault,
  output logic [CLS_W-1:0]      excClass,
  output logic                  refillFlag,
  output logic                  fetchFlag
);
  logic isUser, isSup, isKern, isStore, isFetch;
  logic mapped, allowed, badAddr, tlbFail;
  offSel_e offSel;
  logic [CLS_W-1:0] rawClass;

  assign isUser  = (privMode == 2'b10);
  assign isSup   = (privMode == 2'b01);
  assign isKern  = !isUser && !isSup;
  assign isStore = (reqKind == 2'b01);
  assign isFetch = (reqKind == 2'b10);

  always_comb begin
    mapped  = 1'b0;
    allowed = 1'b1;
    offSel  = OFF_NONE;
    if (!reqAddr[ADDR_W-1]) begin
      mapped = !errLevel;
    end else begin
      unique case (reqAddr[ADDR_W-2:ADDR_W-3])
        2'b00: begin allowed = isKern; offSel = OFF_LOW; end
        2'b01: begin allowed = isKern; offSel = OFF_HIGH; end
        2'b10: begin allowed = !isUser; mapped = 1'b1; end
        default: begin allowed = isKern; mapped = 1'b1; end
      endcase
    end
  end

  assign badAddr = !allowed;
  assign tlbFail = mapped && allowed && (tlbCode != TLB_HIT);

  always_comb begin
    if (badAddr) begin
      rawClass = isStore ? EXC_ADDR_ST : EXC_ADDR_LD;
    end else begin
      case (tlbCode)
        TLB_MISS, TLB_INVAL: rawClass = isStore ? EXC_TLB_ST : EXC_TLB_LD;
        TLB_RDONLY:          rawClass = EXC_MOD;
        TLB_NOEXEC:          rawClass = inhibitExcEn ? EXC_NOEXEC : EXC_TLB_LD;
        TLB_NOREAD:          rawClass = inhibitExcEn ? EXC_NOREAD : EXC_TLB_LD;
        default:             rawClass = isStore ? EXC_ADDR_ST : EXC_ADDR_LD;
      endcase
    end
  end

  assign fault      = reqValid && (badAddr || tlbFail);
  assign excClass   = fault ? rawClass : EXC_NONE;
  assign refillFlag = fault && !badAddr && (tlbCode == TLB_MISS);
  assign fetchFlag  = fault && isFetch;
  assign tlbReq     = reqValid && mapped && allowed;

  assign strobe.fault   = fault;
  assign strobe.capture = fault;
  assign strobe.useTlb  = mapped;
  assign strobe.offSel  = offSel;

  // R4: user mode never reaches the upper half without faulting
  a_r4_user_upper_faults: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && privMode == 2'b10 && reqAddr[ADDR_W-1]) |-> (fault && !tlbReq));

  // R3: the unmapped kernel window never asks the TLB
  a_r3_unmapped_no_lookup: assert property (@(posedge clk) disable iff (!rstN)
    (reqAddr[ADDR_W-1:ADDR_W-2] == 2'b10) |-> !tlbReq);

  // R6: refill only on a no-match result
  a_r6_refill_only_miss: assert property (@(posedge clk) disable iff (!rstN)
    refillFlag |-> (fault && tlbCode == TLB_MISS));

  // R11: without a request nothing faults
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!fault && excClass == EXC_NONE && !tlbReq));
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter logic [ADDR_W-1:0] CTX_INIT    = 32'hA580_0000,
  parameter logic [ADDR_W-1:0] EHI_INIT    = 32'h0000_07C3,
  parameter int                ASID_W      = 8,
  parameter int                INV_POS     = 10,
  parameter int                VPN_LSB     = 13,
  parameter int                CTX_SHIFT   = 9,
  parameter int                CTX_FIELD_W = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] tlbPhys,
  output logic [ADDR_W-1:0] physAddr,
  output logic [ADDR_W-1:0] badVAddr,
  output logic [ADDR_W-1:0] contextReg,
  output logic [ADDR_W-1:0] entryHiReg
);
  localparam logic [ADDR_W-1:0] LOW_BASE  = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 32'hA000_0000;
  localparam logic [ADDR_W-1:0] CTX_FIELD = (ADDR_W'(1) << CTX_FIELD_W) - 1;
  localparam logic [ADDR_W-1:0] CTX_NEW   = CTX_FIELD & ~ADDR_W'(4'hF);
  localparam logic [ADDR_W-1:0] ASID_MASK = (ADDR_W'(1) << ASID_W) - 1;
  localparam logic [ADDR_W-1:0] EHI_KEEP  = ASID_MASK | (ADDR_W'(1) << INV_POS);
  localparam logic [ADDR_W-1:0] VPN_MASK  = ~((ADDR_W'(1) << VPN_LSB) - 1);

  logic [ADDR_W-1:0] base, unmappedPhys;

  always_comb begin
    case (strobe.offSel)
      OFF_LOW:  base = LOW_BASE;
      OFF_HIGH: base = HIGH_BASE;
      default:  base = '0;
    endcase
  end

  assign unmappedPhys = reqAddr - base;
  assign physAddr = strobe.fault  ? '0 :
                    strobe.useTlb ? tlbPhys : unmappedPhys;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badVAddr   <= '0;
      contextReg <= CTX_INIT;
      entryHiReg <= EHI_INIT;
    end else if (strobe.capture) begin
      badVAddr   <= reqAddr;
      contextReg <= (contextReg & ~CTX_FIELD) | ((reqAddr >> CTX_SHIFT) & CTX_NEW);
      entryHiReg <= (entryHiReg & EHI_KEEP) | (reqAddr & VPN_MASK);
    end
  end

  // R9: bad address register follows the faulting address
  a_r9_bad_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (badVAddr == $past(reqAddr)));

  // R9: upper context bits survive a fault
  a_r9_ctx_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (contextReg[ADDR_W-1:CTX_FIELD_W] == $past(contextReg[ADDR_W-1:CTX_FIELD_W])));

  // R10: ASID field survives a fault
  a_r10_asid_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (entryHiReg[ASID_W-1:0] == $past(entryHiReg[ASID_W-1:0])));

  // R11: registers hold without a fault
  a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(badVAddr) && $stable(contextReg) && $stable(entryHiReg)));
endmodule

// File: rtl/vaSegDecode.sv
module vaSegDecode
  import segPkg::*;
#(
  parameter logic [31:0] CTX_INIT    = 32'hA580_0000,
  parameter logic [31:0] EHI_INIT    = 32'h0000_07C3,
  parameter int          ASID_W      = 8,
  parameter int          INV_POS     = 10,
  parameter int          VPN_LSB     = 13,
  parameter int          CTX_SHIFT   = 9,
  parameter int          CTX_FIELD_W = 23
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqKind,
  input  logic [1:0]  privMode,
  input  logic        errLevel,
  input  logic        inhibitExcEn,
  input  logic [2:0]  tlbCode,
  input  logic [31:0] tlbPhys,
  output logic        tlbReq,
  output logic [31:0] physAddr,
  output logic        fault,
  output logic [4:0]  excClass,
  output logic        refillFlag,
  output logic        fetchFlag,
  output logic [31:0] badVAddr,
  output logic [31:0] contextReg,
  output logic [31:0] entryHiReg
);
  ctrlStrobe_t strobe;

  segCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .privMode(privMode), .errLevel(errLevel),
    .inhibitExcEn(inhibitExcEn), .tlbCode(tlbCode), .strobe(strobe),
    .tlbReq(tlbReq), .fault(fault), .excClass(excClass),
    .refillFlag(refillFlag), .fetchFlag(fetchFlag)
  );

  segDatapath #(
    .CTX_INIT(CTX_INIT), .EHI_INIT(EHI_INIT), .ASID_W(ASID_W),
    .INV_POS(INV_POS), .VPN_LSB(VPN_LSB), .CTX_SHIFT(CTX_SHIFT),
    .CTX_FIELD_W(CTX_FIELD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .tlbPhys(tlbPhys), .physAddr(physAddr), .badVAddr(badVAddr),
    .contextReg(contextReg), .entryHiReg(entryHiReg)
  );
endmodule

// File: tb/vaSegDecode_bench.sv
`timescale 1ns/1ps
module vaSegDecode_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0] reqKind = '0;
  logic [1:0] privMode = '0;
  logic errLevel = 1'b0;
  logic inhibitExcEn = 1'b0;
  logic [2:0] tlbCode = '0;
  logic [31:0] tlbPhys = '0;
  logic tlbReq, fault, refillFlag, fetchFlag;
  logic [31:0] physAddr, badVAddr, contextReg, entryHiReg;
  logic [4:0] excClass;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vaSegDecode u_vaSegDecode (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .privMode(privMode), .errLevel(errLevel),
    .inhibitExcEn(inhibitExcEn), .tlbCode(tlbCode), .tlbPhys(tlbPhys),
    .tlbReq(tlbReq), .physAddr(physAddr), .fault(fault), .excClass(excClass),
    .refillFlag(refillFlag), .fetchFlag(fetchFlag), .badVAddr(badVAddr),
    .contextReg(contextReg), .entryHiReg(entryHiReg)
  );

  typedef struct {
    string       tag;
    logic        tlbReq;
    logic [31:0] phys;
    logic        fault;
    logic [4:0]  cls;
    logic        refill;
    logic        fetch;
    logic [31:0] bad;
    logic [31:0] ctx;
    logic [31:0] ehi;
  } item_t;

  item_t expQ[$];
  logic [31:0] mBad = 32'h0;
  logic [31:0] mCtx = 32'hA580_0000;
  logic [31:0] mEhi = 32'h0000_07C3;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic v, input logic [31:0] a, input logic [1:0] kind,
                       input logic [1:0] mode, input logic el, input logic ie,
                       input logic [2:0] code, input logic [31:0] tp);
    item_t it;
    logic user, sup, kern, mapped, ok, store;
    logic [31:0] off;
    logic [4:0] cls;
    logic flt;
    @(negedge clk);
    reqValid = v; reqAddr = a; reqKind = kind; privMode = mode;
    errLevel = el; inhibitExcEn = ie; tlbCode = code; tlbPhys = tp;
    user = (mode == 2); sup = (mode == 1); kern = !(user || sup);
    store = (kind == 1);
    mapped = 0; ok = 1; off = 0;
    if (a <= 32'h7FFF_FFFF) mapped = !el;
    else if (a < 32'hA000_0000) begin ok = kern; off = 32'h8000_0000; end
    else if (a < 32'hC000_0000) begin ok = kern; off = 32'hA000_0000; end
    else if (a < 32'hE000_0000) begin ok = kern || sup; mapped = 1; end
    else begin ok = kern; mapped = 1; end
    flt = v && (!ok || (mapped && code != 0));
    if (!ok) cls = store ? 5'd5 : 5'd4;
    else if (code == 1 || code == 2) cls = store ? 5'd3 : 5'd2;
    else if (code == 3) cls = 5'd1;
    else if (code == 4) cls = ie ? 5'd20 : 5'd2;
    else if (code == 5) cls = ie ? 5'd19 : 5'd2;
    else cls = store ? 5'd5 : 5'd4;
    it.tag = tag;
    it.tlbReq = v && mapped && ok;
    it.fault = flt;
    it.cls = flt ? cls : 5'd0;
    it.refill = flt && ok && code == 1;
    it.fetch = flt && kind == 2;
    it.phys = flt ? 32'h0 : (mapped ? tp : a - off);
    if (flt) begin
      mBad = a;
      mCtx = (mCtx & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
      mEhi = (mEhi & 32'h0000_04FF) | (a & 32'hFFFF_E000);
    end
    it.bad = mBad; it.ctx = mCtx; it.ehi = mEhi;
    expQ.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        chk(it.tag, "tlbReq", 32'(tlbReq), 32'(it.tlbReq));
        chk(it.tag, "physAddr", physAddr, it.phys);
        chk(it.tag, "fault", 32'(fault), 32'(it.fault));
        chk(it.tag, "excClass", 32'(excClass), 32'(it.cls));
        chk(it.tag, "refillFlag", 32'(refillFlag), 32'(it.refill));
        chk(it.tag, "fetchFlag", 32'(fetchFlag), 32'(it.fetch));
        chk(it.tag, "R9 badVAddr", badVAddr, it.bad);
        chk(it.tag, "R9 context", contextReg, it.ctx);
        chk(it.tag, "R10 entryHi", entryHiReg, it.ehi);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reset badVAddr", badVAddr, 32'h0);
    chk("R12", "reset context", contextReg, 32'hA580_0000);
    chk("R12", "reset entryHi", entryHiReg, 32'h0000_07C3);
    @(negedge clk);
    rstN = 1'b1;
    // R1 identity user segment
    drive("R1 ident user", 1, 32'h1234_5678, 2'd0, 2'd2, 1, 0, 3'd1, 32'hDEAD_0000);
    drive("R1 ident top", 1, 32'h7FFF_FFFF, 2'd1, 2'd0, 1, 0, 3'd0, 32'h0);
    // R2 mapped user segment hit
    drive("R2 mapped hit", 1, 32'h0040_1000, 2'd0, 2'd2, 0, 0, 3'd0, 32'h0ABC_D123);
    // R3 kernel windows
    drive("R3 low window", 1, 32'h8012_3456, 2'd0, 2'd0, 0, 0, 3'd1, 32'h0);
    drive("R3 high window mode11", 1, 32'hBFFF_FFFC, 2'd1, 2'd3, 0, 0, 3'd0, 32'h0);
    drive("R3 low window top", 1, 32'h9FFF_FFFF, 2'd2, 2'd0, 0, 0, 3'd0, 32'h0);
    // R4 forbidden segments
    drive("R4 user low load", 1, 32'h8000_0000, 2'd0, 2'd2, 0, 0, 3'd0, 32'h0);
    drive("R4 user high store", 1, 32'hA000_0010, 2'd1, 2'd2, 0, 0, 3'd0, 32'h0);
    drive("R4 R8 sup fetch", 1, 32'h9000_0000, 2'd2, 2'd1, 0, 0, 3'd0, 32'h0);
    drive("R4 user sup seg", 1, 32'hC000_1000, 2'd0, 2'd2, 0, 0, 3'd0, 32'h0);
    drive("R4 sup top seg", 1, 32'hE000_0000, 2'd1, 2'd1, 0, 0, 3'd0, 32'h0);
    // R5 mapped upper segments
    drive("R5 sup seg", 1, 32'hC000_1000, 2'd0, 2'd1, 0, 0, 3'd0, 32'h1111_2000);
    drive("R5 sup seg edge", 1, 32'hDFFF_FFFF, 2'd0, 2'd1, 0, 0, 3'd0, 32'h2222_3000);
    drive("R5 kern top seg", 1, 32'hE000_0000, 2'd0, 2'd0, 0, 0, 3'd0, 32'h3333_4000);
    // R6 TLB failures
    drive("R6 miss store", 1, 32'h0ABC_E000, 2'd1, 2'd2, 0, 0, 3'd1, 32'h0);
    drive("R6 miss load", 1, 32'hC123_4567, 2'd3, 2'd0, 0, 0, 3'd1, 32'h0);
    drive("R6 invalid store", 1, 32'h5555_5555, 2'd1, 2'd0, 0, 0, 3'd2, 32'h0);
    drive("R6 invalid load", 1, 32'h2000_2000, 2'd0, 2'd2, 0, 0, 3'd2, 32'h0);
    drive("R6 not writable", 1, 32'hF0F0_F0F0, 2'd1, 2'd0, 0, 0, 3'd3, 32'h0);
    // R7 inhibit classes
    drive("R7 R8 exec ie1", 1, 32'h3000_4000, 2'd2, 2'd2, 0, 1, 3'd4, 32'h0);
    drive("R7 exec ie0", 1, 32'h3000_6000, 2'd2, 2'd2, 0, 0, 3'd4, 32'h0);
    drive("R7 read ie1", 1, 32'h6000_8000, 2'd0, 2'd1, 0, 1, 3'd5, 32'h0);
    drive("R7 read ie0", 1, 32'h6000_A000, 2'd0, 2'd1, 0, 0, 3'd5, 32'h0);
    // R11 no request and no-fault hold
    drive("R11 unstrobed bad", 0, 32'hA000_0000, 2'd1, 2'd2, 0, 0, 3'd1, 32'h0);
    drive("R11 unstrobed mapped", 0, 32'h0100_0000, 2'd0, 2'd2, 0, 0, 3'd1, 32'h7777_0000);
    drive("R11 hit hold", 1, 32'h0100_0000, 2'd0, 2'd2, 0, 0, 3'd0, 32'h7777_0000);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule